// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block receives serial words from an external master that drives both the shift clock and the data line. Both pins pass through two-flop synchronizers into the system clock domain. On each detected falling edge of the synchronized clock, one data bit is sampled, least significant bit first. A word is 8 bits, or 9 bits when nine-bit mode is selected. When the last bit of a word arrives, the assembled word moves into a data register. At the same time a full flag is raised and, if enabled, an interrupt request. The system clock only has to sample the pins, and the shift clock comes from outside. The block can therefore finish a word while the rest of the system waits in a low-power state, and that interrupt can serve as the wake-up request.

Software sees three byte-wide locations. The first is a control/status byte that holds the enables, the error bits and the ninth data bit. The second is the received data byte; reading it empties the register. The third is a mode byte that selects synchronous operation, the clock source and the interrupt enable. A word that completes while the data register is still full is discarded and raises the overrun bit. The receiver then stays blocked until software clears the continuous-receive enable.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, every register location reads 0x00, and the full flag and interrupt request are low.
- R2: Bits are taken only when the mode byte has synchronous mode = 1 and clock-source = 0, and the status byte has port enable = 1 and continuous-receive enable = 1. Otherwise falling edges on the shift clock leave the data register, the full flag and the status byte unchanged.
- R3: The single-receive enable (status bit 5) can be written and read back, but has no effect on reception.
- R4: Data is sampled on falling shift-clock edges, LSB first. When the 8th bit (8-bit mode) or 9th bit (9-bit mode) arrives, the low 8 bits load into the data register (address 1) and the full flag sets. This is visible 3 system clocks after the pin edge.
- R5: The interrupt output is high exactly while the full flag is set and the interrupt enable (mode bit 2) is 1.
- R6: In 9-bit mode (status bit 6 = 1), the 9th bit received is presented in status bit 0. In 8-bit mode that bit reads 0 after the next word.
- R7: A read strobe at address 1 returns the data byte and clears the full flag on that clock edge.
- R8: A word that completes while the full flag is set is discarded, sets overrun (status bit 1) and leaves the data register unchanged. Later words are ignored while overrun is set.
- R9: Writing continuous-receive enable to 0 clears overrun one clock later and discards any partially received word.
- R10: Status bit 2, the framing error, always reads 0.
- R11: Register map. Address 0 is status/control: bit 7 port enable, bit 6 nine-bit, bit 5 single-receive enable, bit 4 continuous-receive enable, bit 3 address-detect enable (stored, no effect), bit 2 framing, bit 1 overrun, bit 0 ninth bit. Writes load bits 7..3. Address 2 is the mode byte: bit 2 interrupt enable, bit 1 clock-source, bit 0 synchronous mode. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_pin | input | 1 | External shift clock, asynchronous |
| sdat_pin | input | 1 | External serial data, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect at address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address (combinational) |
| rx_full | output | 1 | Data register holds an unread word |
| rx_irq | output | 1 | Receive-complete interrupt / wake-up request |

## Verification
A wrong bit counter or shift register shows up as a wrong data byte or wrong ninth bit. It is seen three clocks after the falling edge that completes the word, and it can also appear as a full flag that rises one edge early or late. A stuck overrun or missing clear shows in status bit 1 within two clocks of the control write. A wrong enable decode shows as a full flag rising during a pattern that should have been ignored. The bench's behavioural model predicts every port on every clock, so any such deviation is reported in the cycle it appears.

// File: rtl/ssr_pkg.sv
// Package: shared register addresses and word-size constants for the
// synchronous slave receiver. Assumes a 2-bit register address space.
package ssr_pkg;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned WORD_MAX = 9;

    localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] A_MODE = 2'd2;

    typedef struct packed {
        logic port_en;
        logic nine;
        logic sren;
        logic cren;
        logic adden;
    } ctrl_t;

    typedef struct packed {
        logic ien;
        logic master;
        logic sync;
    } mode_t;
endpackage

// File: rtl/ssr_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent (no bus coherency required).
module ssr_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pins into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Pass the value down the synchronizer chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ssr_shifter.sv
// Module: bit counter and word assembler. Stores one bit per detected
// falling edge, LSB first, and pulses done with the complete word.
// Assumes fall is a single-cycle strobe in the system clock domain.
module ssr_shifter #(
    parameter int unsigned WMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            go,
    input  logic            nine,
    input  logic            fall,
    input  logic            din,
    output logic            done,
    output logic [WMAX-1:0] word
);
    localparam int unsigned CNT_W = $clog2(WMAX);

    logic [CNT_W-1:0] bit_cnt;
    logic [WMAX-1:0]  shreg;
    logic [CNT_W-1:0] last_idx;

    // Index of the final bit for the selected word size.
    assign last_idx = nine ? CNT_W'(WMAX-1) : CNT_W'(WMAX-2);
    assign done     = go && fall && (bit_cnt == last_idx);

    // Present the stored bits merged with the arriving bit.
    always_comb begin
        word          = shreg;
        word[bit_cnt] = din;
    end

    // Advance the counter and store the bit; restart on clear or completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (go && fall) begin
            if (bit_cnt == last_idx) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= word;
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(WMAX-1)); // R4
    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (bit_cnt == $past(bit_cnt) || bit_cnt == '0)); // R2
endmodule

// File: rtl/sync_slave_rx.sv
// Module: synchronous serial slave receiver top. Holds the control, mode
// and data registers, decodes the slave-receive enable and reports
// completion, overrun and interrupt. Assumes the external shift clock is
// slow enough for at least two system clocks per level.
module sync_slave_rx
    import ssr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_pin,
    input  logic        sdat_pin,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        rx_full,
    output logic        rx_irq
);
    ctrl_t               ctrl_q;
    mode_t               mode_q;
    logic [BYTE_W-1:0]   data_q;
    logic                ninth_q;
    logic                ovr_q;
    logic                full_q;
    logic [1:0]          pins_s;
    logic                sck_d;
    logic                fall;
    logic                go;
    logic                done;
    logic [WORD_MAX-1:0] word;
    logic                rd_data;

    ssr_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sck_pin, sdat_pin}),
        .sync_out (pins_s)
    );

    // Delay the synchronized clock once for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= pins_s[1];
    end

    assign fall    = sck_d && !pins_s[1];
    assign go      = ctrl_q.port_en && mode_q.sync && !mode_q.master
                     && ctrl_q.cren && !ovr_q;
    assign rd_data = reg_rd && (reg_addr == A_DATA);

    ssr_shifter #(.WMAX(WORD_MAX)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!ctrl_q.cren),
        .go    (go),
        .nine  (ctrl_q.nine),
        .fall  (fall),
        .din   (pins_s[0]),
        .done  (done),
        .word  (word)
    );

    // Load control and mode bytes from register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_STAT) ctrl_q <= ctrl_t'(reg_wdata[7:3]);
            if (reg_addr == A_MODE) mode_q <= mode_t'(reg_wdata[2:0]);
        end
    end

    // Transfer completed words, track full and overrun state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            ninth_q <= 1'b0;
            full_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (rd_data) full_q <= 1'b0;
            if (!ctrl_q.cren) begin
                ovr_q <= 1'b0;
            end else if (done) begin
                if (full_q && !rd_data) begin
                    ovr_q <= 1'b1;
                end else begin
                    data_q  <= word[BYTE_W-1:0];
                    ninth_q <= ctrl_q.nine ? word[WORD_MAX-1] : 1'b0;
                    full_q  <= 1'b1;
                end
            end
        end
    end

    // Return the byte for the current address.
    always_comb begin
        unique case (reg_addr)
            A_STAT:  reg_rdata = {ctrl_q, 1'b0, ovr_q, ninth_q};
            A_DATA:  reg_rdata = data_q;
            A_MODE:  reg_rdata = {5'b0, mode_q};
            default: reg_rdata = '0;
        endcase
    end

    assign rx_full = full_q;
    assign rx_irq  = full_q && mode_q.ien;

    AST_FULL_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> $past(done)); // R4
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && $past(ovr_q)) |-> $stable(data_q)); // R8
    AST_CREN_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.cren |=> !ovr_q); // R9
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> !full_q); // R7
endmodule

// File: tb/sync_slave_rx_test.sv
`timescale 1ns/1ps
module sync_slave_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_pin = 1'b1;
    logic       sdat_pin = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       rx_full;
    logic       rx_irq;

    int compared = 0;
    int mismatched = 0;
    bit cmp_on = 0;
    bit finished = 0;
    string cur = "R1";

    // Behavioural model state
    bit m_pe, m_nine, m_sren, m_cren, m_adden, m_ien, m_master, m_sync;
    int m_cnt, m_sh, m_data;
    bit m_full, m_ovr, m_ninth;
    int pend_bit = 0, pend_wr = 0, pend_rd = 0;
    bit pb_val;
    int pw_addr, pw_data;

    always #4 clk = ~clk;

    sync_slave_rx uut (
        .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .sdat_pin(sdat_pin),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_full(rx_full), .rx_irq(rx_irq)
    );

    function automatic int exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return {m_pe, m_nine, m_sren, m_cren, m_adden, 1'b0, m_ovr, m_ninth};
            2'd1: return m_data;
            2'd2: return {5'b0, m_ien, m_master, m_sync};
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        {m_pe, m_nine, m_sren, m_cren, m_adden, m_ien, m_master, m_sync} = '0;
        m_cnt = 0; m_sh = 0; m_data = 0;
        m_full = 0; m_ovr = 0; m_ninth = 0;
    endtask

    task automatic model_bit(input bit d);
        int last;
        if (m_pe && m_sync && !m_master && m_cren && !m_ovr) begin
            last = m_nine ? 8 : 7;
            m_sh = m_sh | (int'(d) << m_cnt);
            if (m_cnt == last) begin
                if (m_full) m_ovr = 1;
                else begin
                    m_data  = m_sh & 8'hFF;
                    m_ninth = m_nine ? m_sh[8] : 1'b0;
                    m_full  = 1;
                end
                m_cnt = 0; m_sh = 0;
            end else m_cnt++;
        end
    endtask

    // Advance the model and compare every port on each falling clock edge.
    always @(negedge clk) begin
        if (!rst_n) model_reset();
        else begin
            if (!m_cren) begin m_ovr = 0; m_cnt = 0; m_sh = 0; end
            if (pend_bit > 0) begin pend_bit--; if (pend_bit == 0) model_bit(pb_val); end
            if (pend_rd > 0) begin pend_rd--; if (pend_rd == 0) m_full = 0; end
            if (pend_wr > 0) begin
                pend_wr--;
                if (pend_wr == 0) begin
                    if (pw_addr == 0) {m_pe, m_nine, m_sren, m_cren, m_adden} = pw_data[7:3];
                    if (pw_addr == 2) {m_ien, m_master, m_sync} = pw_data[2:0];
                end
            end
        end
        if (cmp_on) begin
            compared++;
            if (rx_full !== m_full) begin
                mismatched++;
                $display("FAIL %s rx_full got %b exp %b at %0t", cur, rx_full, m_full, $time);
            end else if (rx_irq !== (m_full && m_ien)) begin
                mismatched++;
                $display("FAIL %s rx_irq got %b exp %b at %0t", cur, rx_irq, m_full && m_ien, $time);
            end else if (reg_rdata !== 8'(exp_rdata(reg_addr))) begin
                mismatched++;
                $display("FAIL %s reg_rdata[addr %0d] got %h exp %h at %0t",
                         cur, reg_addr, reg_rdata, 8'(exp_rdata(reg_addr)), $time);
            end
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic wr(input int a, input int d);
        tick(); reg_wr = 1; reg_addr = 2'(a); reg_wdata = 8'(d);
        pw_addr = a; pw_data = d; pend_wr = 2;
        tick(); reg_wr = 0; reg_addr = 2'd0;
        repeat (2) tick();
    endtask

    task automatic rd_data();
        tick(); reg_rd = 1; reg_addr = 2'd1; pend_rd = 2;
        tick(); reg_rd = 0; reg_addr = 2'd0;
        repeat (2) tick();
    endtask

    task automatic send_bit(input bit d);
        tick(); sdat_pin = d; sck_pin = 1;
        repeat (3) tick();
        sck_pin = 0; pb_val = d; pend_bit = 4;
        repeat (4) tick();
        sck_pin = 1;
    endtask

    task automatic send_word(input int w, input int n);
        for (int i = 0; i < n; i++) send_bit(w[i]);
        repeat (6) tick();
    endtask

    initial begin
        repeat (3) tick();
        cmp_on = 1;
        cur = "R1"; repeat (3) tick();     // reset values
        rst_n = 1;
        repeat (3) tick();
        cur = "R11"; wr(3, 8'hFF);         // address 3 stays 0
        tick(); reg_addr = 2'd3; tick(); tick(); reg_addr = 2'd0;
        cur = "R2"; wr(0, 8'h90);          // enabled, but sync mode off
        send_word(8'h5A, 8);
        wr(2, 8'h03);                      // sync on, internal clock source
        send_word(8'h5A, 8);
        cur = "R3"; wr(2, 8'h01); wr(0, 8'hA8);  // single-receive only
        send_word(8'h5A, 8);
        cur = "R4"; wr(0, 8'h90); send_word(8'hA5, 8);
        cur = "R10"; repeat (4) tick();
        cur = "R7"; rd_data();
        cur = "R5"; wr(2, 8'h05); send_word(8'h3C, 8);
        cur = "R7"; rd_data();
        cur = "R3"; wr(0, 8'hB8); send_word(8'hC3, 8); rd_data();
        cur = "R6"; wr(0, 8'hD0); send_word(9'h15A, 9); rd_data();
        send_word(9'h0FF, 9); rd_data();
        wr(0, 8'h90); send_word(8'h01, 8); rd_data();
        cur = "R8"; send_word(8'h11, 8); send_word(8'h22, 8);
        send_word(8'h33, 8); rd_data(); send_word(8'h44, 8);
        cur = "R9"; wr(0, 8'h80); wr(0, 8'h90);
        send_word(8'h07, 3);
        wr(0, 8'h80); wr(0, 8'h90);
        send_word(8'h81, 8); rd_data();
        repeat (4) tick();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog %s got timeout exp completion", cur);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule